// File: doc/BRIEF.md
# Byte-Lane Access Permission Gate

This block sits between a simple register bus and one 32-bit data-port word of a peripheral. Every byte lane of the word has its own 3-bit permission code. For each access the block works out the class of the requester, looks up what that class may do in each strobed lane, and lets through only the permitted part of the access. Write strobes for lanes that are not permitted are dropped before they reach the register file. Read data for lanes that are not permitted is returned as zero. Any access that touches a forbidden lane raises an error pulse on the following clock.

There are three requester classes: user non-secure, user secure and privileged secure. A privileged access that is not secure has no class of its own and is handled as user non-secure. The eight codes form a ladder: each step takes rights away from the least trusted class first. A separate bypass setting lets every access through and keeps the lane codes stored underneath it. The configuration port writes one code at a time to a chosen set of lanes.

Top module: `byte_attr_gate`

## Requirements
- R1: The requester class is user non-secure when `bus_secure` is 0, whatever `bus_priv` is. It is user secure when `bus_secure`=1 and `bus_priv`=0, and privileged secure when both are 1.
- R2: Code 0 gives read/write to every class. Code 1 gives user non-secure read only and the two secure classes read/write. Code 2 gives user non-secure nothing and the two secure classes read/write. Code 3 gives both user classes read only and privileged secure read/write. Code 4 gives user non-secure nothing, user secure read only and privileged secure read/write. Code 5 gives only privileged secure any right, read/write. Code 6 gives privileged secure read only and the rest nothing. Code 7 gives nothing to anyone.
- R3: Lane i covers data bits 8i+7..8i and strobe bit i. Each lane is judged only by its own stored code.
- R4: In a write (`bus_valid`=1, `bus_write`=1), `rf_wr_strb[i]` is 1 exactly when `bus_be[i]`=1 and lane i grants write. This output is combinational, in the same cycle as the access. It is all zero when no write is presented.
- R5: In a read (`bus_valid`=1, `bus_write`=0), lane i of `rd_data` equals lane i of `rf_rdata` when `bus_be[i]`=1 and lane i grants read. Otherwise that lane is zero. `rd_data` is zero whenever no read is presented.
- R6: `acc_err` is registered. It is 1 in the cycle after an access in which at least one strobed lane lacked the needed right. Otherwise it is 0, including after cycles with no access.
- R7: A configuration write with `cfg_code`=8'h80 sets bypass. While bypass is set every strobed lane is granted read and write, and the stored lane codes are left as they were. A configuration write with any code 0..7 clears bypass, even when `cfg_lanes` is zero.
- R8: A configuration write with a code 0..7 stores `cfg_code[2:0]` into every lane whose `cfg_lanes` bit is 1 and leaves the other lanes alone. Any code other than 0..7 and 8'h80 changes nothing. A new configuration applies from the next cycle.
- R9: After reset every lane holds code 0, bypass is clear and `acc_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_lanes | input | LANES | Lanes that take the written code |
| cfg_code | input | 8 | Permission code 0..7, or 8'h80 for bypass |
| bus_valid | input | 1 | An access is presented this cycle |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_be | input | LANES | Byte strobes of the access |
| bus_priv | input | 1 | Requester is privileged |
| bus_secure | input | 1 | Requester is secure |
| rf_rdata | input | 8*LANES | Raw read data from the register word |
| rf_wr_strb | output | LANES | Filtered write strobes to the register word |
| rd_data | output | 8*LANES | Read data after masking |
| acc_err | output | 1 | One-cycle error for a blocked access |

## Verification
The assertions assume that bus inputs are stable around the sampling edge. They also assume that a cycle with `bus_valid` low carries no access, whatever the other bus inputs hold, so the error checks tie `acc_err` to the previous cycle's valid accesses only. The stimulus drives every input on the falling edge. Between vectors it holds `bus_valid` low, and it never sends a configuration write in the same cycle as an access. It sweeps all eight codes over every lane position, together with all four privilege/security combinations, both directions and all sixteen strobe patterns.

// File: rtl/byte_attr_gate.sv
module byte_attr_gate #(
  parameter int LANES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [LANES-1:0]   cfg_lanes,
  input  logic [7:0]         cfg_code,
  input  logic               bus_valid,
  input  logic               bus_write,
  input  logic [LANES-1:0]   bus_be,
  input  logic               bus_priv,
  input  logic               bus_secure,
  input  logic [LANES*8-1:0] rf_rdata,
  output logic [LANES-1:0]   rf_wr_strb,
  output logic [LANES*8-1:0] rd_data,
  output logic               acc_err
);
  localparam int CW = 3;
  localparam logic [7:0] BYPASS_CODE = 8'h80;

  logic [CW-1:0]    attr_q [LANES];
  logic             bypass_q;
  logic [1:0]       cls;
  logic [LANES-1:0] wr_ok, rd_ok, wr_req, rd_req;
  logic             code_ok;

  // 0: user non-secure (also privileged non-secure), 1: user secure, 2: privileged secure
  assign cls     = !bus_secure ? 2'd0 : (bus_priv ? 2'd2 : 2'd1);
  assign code_ok = (cfg_code[7:CW] == '0);
  assign wr_req  = {LANES{bus_valid &  bus_write}} & bus_be;
  assign rd_req  = {LANES{bus_valid & ~bus_write}} & bus_be;

  // rights per code as {priv_sec, user_sec, user_ns}, each {rd, wr}
  function automatic logic [1:0] grant(input logic [CW-1:0] code, input logic [1:0] c);
    logic [5:0] row;
    case (code)
      3'd0:    row = 6'b11_11_11;
      3'd1:    row = 6'b11_11_10;
      3'd2:    row = 6'b11_11_00;
      3'd3:    row = 6'b11_10_10;
      3'd4:    row = 6'b11_10_00;
      3'd5:    row = 6'b11_00_00;
      3'd6:    row = 6'b10_00_00;
      default: row = 6'b00_00_00;
    endcase
    case (c)
      2'd0:    grant = row[1:0];
      2'd1:    grant = row[3:2];
      2'd2:    grant = row[5:4];
      default: grant = 2'b00;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bypass_q <= 1'b0;
      for (int i = 0; i < LANES; i++) attr_q[i] <= '0;
    end else if (cfg_we) begin
      if (cfg_code == BYPASS_CODE) begin
        bypass_q <= 1'b1;
      end else if (code_ok) begin
        bypass_q <= 1'b0;
        for (int i = 0; i < LANES; i++)
          if (cfg_lanes[i]) attr_q[i] <= cfg_code[CW-1:0];
      end
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [1:0] right;
    assign right       = bypass_q ? 2'b11 : grant(attr_q[g], cls);
    assign rd_ok[g]    = right[1];
    assign wr_ok[g]    = right[0];
    assign rd_data[g*8 +: 8] = (rd_req[g] & rd_ok[g]) ? rf_rdata[g*8 +: 8] : 8'h00;
  end

  assign rf_wr_strb = wr_req & wr_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_err <= 1'b0;
    else        acc_err <= |((wr_req & ~wr_ok) | (rd_req & ~rd_ok));
  end
endmodule

// File: rtl/byte_attr_gate_chk.sv
module byte_attr_gate_chk #(
  parameter int LANES = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_we,
  input logic [7:0]         cfg_code,
  input logic               bus_valid,
  input logic               bus_write,
  input logic [LANES-1:0]   bus_be,
  input logic [LANES-1:0]   rf_wr_strb,
  input logic [LANES*8-1:0] rd_data,
  input logic               acc_err,
  input logic               bypass_q
);
  p_wr_in_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_wr_strb & ~(bus_be & {LANES{bus_valid && bus_write}})) == '0);

  p_rd_idle_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_valid || bus_write) |-> rd_data == '0);

  p_err_after_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && ((bus_be & ~rf_wr_strb) != '0)) |=> acc_err);

  p_err_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |=> !acc_err);

  p_bypass_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass_q && bus_valid && bus_write) |-> rf_wr_strb == bus_be);

  p_bypass_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_code == 8'h80) |=> bypass_q);
endmodule

bind byte_attr_gate byte_attr_gate_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_code(cfg_code),
  .bus_valid(bus_valid), .bus_write(bus_write), .bus_be(bus_be),
  .rf_wr_strb(rf_wr_strb), .rd_data(rd_data), .acc_err(acc_err),
  .bypass_q(bypass_q)
);

// File: tb/byte_attr_gate_bench.sv
`timescale 1ns/1ps
module byte_attr_gate_bench;
  localparam int LANES = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [LANES-1:0] cfg_lanes = '0;
  logic [7:0] cfg_code = '0;
  logic bus_valid = 1'b0, bus_write = 1'b0, bus_priv = 1'b0, bus_secure = 1'b0;
  logic [LANES-1:0] bus_be = '0;
  logic [31:0] rf_rdata = '0;
  logic [LANES-1:0] rf_wr_strb;
  logic [31:0] rd_data;
  logic acc_err;

  int vectors = 0;
  int fails = 0;
  logic [2:0] lane_code [LANES];

  always #2.5 clk = ~clk;

  byte_attr_gate #(.LANES(LANES)) u_byte_attr_gate (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_lanes(cfg_lanes), .cfg_code(cfg_code),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_be(bus_be), .bus_priv(bus_priv),
    .bus_secure(bus_secure), .rf_rdata(rf_rdata), .rf_wr_strb(rf_wr_strb),
    .rd_data(rd_data), .acc_err(acc_err)
  );

  // may_rd / may_wr from the ladder, class 0 = user ns, 1 = user sec, 2 = priv sec
  function automatic logic may_wr(input int code, input int c);
    if (c == 0) return code == 0;
    if (c == 1) return code <= 2;
    return code <= 5;
  endfunction
  function automatic logic may_rd(input int code, input int c);
    if (c == 0) return code <= 1 || code == 3;
    if (c == 1) return code <= 4;
    return code <= 6;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cfg(input logic [LANES-1:0] lanes, input logic [7:0] code);
    @(negedge clk);
    bus_valid = 1'b0; cfg_we = 1'b1; cfg_lanes = lanes; cfg_code = code;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic access(input logic w, input logic [3:0] be, input logic p, input logic s,
                        input logic [31:0] data);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = w; bus_be = be; bus_priv = p; bus_secure = s; rf_rdata = data;
    #1;
  endtask

  task automatic idle_then_err(input string tag, input logic exp);
    @(posedge clk); #1;
    check(tag, {31'd0, acc_err}, {31'd0, exp});
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    check("R9 err after reset", {31'd0, acc_err}, 32'd0);
    check("R5 idle rd zero", rd_data, 32'd0);

    // R9: all lanes code 0 after reset, user non-secure may write all
    access(1'b1, 4'hF, 1'b0, 1'b0, 32'h0);
    check("R9 reset codes grant write", {28'd0, rf_wr_strb}, 32'hF);
    idle_then_err("R9 no err", 1'b0);

    // exhaustive sweep: lane i gets code (base + 3*i) % 8
    for (int base = 0; base < 8; base++) begin
      for (int i = 0; i < LANES; i++) begin
        lane_code[i] = 3'((base + 3 * i) % 8);
        cfg(4'(1 << i), {5'd0, lane_code[i]});
      end
      for (int ps = 0; ps < 4; ps++) begin
        for (int w = 0; w < 2; w++) begin
          for (int be = 0; be < 16; be++) begin
            logic p, s;
            int c;
            logic [3:0] exp_strb;
            logic [31:0] exp_rd, data;
            logic exp_err;
            p = ps[0]; s = ps[1];
            c = !s ? 0 : (p ? 2 : 1);  // R1
            data = 32'h9E37_79B9 ^ (base * 32'h0101_0101) ^ (be << 8);
            exp_strb = '0; exp_rd = '0; exp_err = 1'b0;
            for (int i = 0; i < LANES; i++) begin
              if (be[i]) begin
                if (w == 1) begin
                  if (may_wr(lane_code[i], c)) exp_strb[i] = 1'b1; else exp_err = 1'b1;
                end else begin
                  if (may_rd(lane_code[i], c)) exp_rd[i*8 +: 8] = data[i*8 +: 8];
                  else exp_err = 1'b1;
                end
              end
            end
            access(w[0], be[3:0], p, s, data);
            check("R1 R2 R3 R4 write strobes", {28'd0, rf_wr_strb}, {28'd0, exp_strb});
            check("R3 R5 read data", rd_data, exp_rd);
            idle_then_err("R6 error pulse", exp_err);
          end
        end
      end
    end
    @(negedge clk); #1;
    check("R6 quiet after idle", {31'd0, acc_err}, 32'd0);

    // R7 bypass
    cfg(4'hF, 8'h07);
    access(1'b1, 4'hF, 1'b1, 1'b1, 32'h0);
    check("R2 code 7 blocks", {28'd0, rf_wr_strb}, 32'h0);
    idle_then_err("R6 blocked err", 1'b1);
    cfg(4'h0, 8'h80);
    access(1'b1, 4'hF, 1'b0, 1'b0, 32'h0);
    check("R7 bypass write", {28'd0, rf_wr_strb}, 32'hF);
    idle_then_err("R7 bypass no err", 1'b0);
    access(1'b0, 4'hF, 1'b0, 1'b0, 32'hCAFE_F00D);
    check("R7 bypass read", rd_data, 32'hCAFE_F00D);
    idle_then_err("R7 bypass read no err", 1'b0);
    cfg(4'h0, 8'h00);
    access(1'b1, 4'hF, 1'b1, 1'b1, 32'h0);
    check("R7 clear keeps codes", {28'd0, rf_wr_strb}, 32'h0);
    idle_then_err("R7 err after clear", 1'b1);

    // R8 ignored codes and lane-selective writes
    cfg(4'hF, 8'h41);
    cfg(4'hF, 8'h08);
    access(1'b1, 4'hF, 1'b1, 1'b1, 32'h0);
    check("R8 illegal code ignored", {28'd0, rf_wr_strb}, 32'h0);
    idle_then_err("R8 still blocked", 1'b1);
    cfg(4'b0010, 8'h00);
    access(1'b1, 4'hF, 1'b0, 1'b0, 32'h0);
    check("R8 lane select", {28'd0, rf_wr_strb}, 32'h2);
    idle_then_err("R8 partial err", 1'b1);
    access(1'b0, 4'hF, 1'b0, 1'b0, 32'h1234_5678);
    check("R8 lane select read", rd_data, 32'h0000_5600);
    idle_then_err("R8 partial read err", 1'b1);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule